// File: doc/BRIEF.md
# Programmable Down-Count Interval Timer

This block counts down from a software-chosen starting value at a rate set by a power-of-two prescaler. It runs either once or periodically. When the count reaches zero, it raises a one-cycle interrupt request that carries an 8-bit vector. The vector comes from a timer entry register, and that register's mask bit can silence the request.

Three register-style write strobes set the block up:
- the divide configuration,
- the timer entry,
- the initial count.

The current count is always visible on an output. A write strobe aimed at the current count is accepted and ignored. Address decode and the interrupt controller that takes the request sit outside the block.

The divide configuration keeps bits 3, 1 and 0 and drops the rest. Those three bits form a code. The prescale shift is that code plus one, wrapped to three bits. As a result, the all-ones code divides by 1 and the all-zeros code divides by 2.

Top module: `intvl_timer`

## Requirements
- R1: A divide-configuration write stores the written 4-bit value ANDed with 4'b1011, and `div_cfg` shows the stored value from the next cycle. Bit 2 never reads back as 1.
- R2: The code is {cfg[3], cfg[1], cfg[0]} and the shift is (code + 1) mod 8. After a load, the count decrements at every 2^shift-th rising edge.
- R3: An initial-count write places the written value in `cur_count` at the next edge and restarts the prescaler. The first decrement then follows 2^shift edges later.
- R4: In one-shot mode (entry bit 17 = 0), the count decreases to 0 and stays at 0.
- R5: In periodic mode (entry bit 17 = 1), the count goes from 0 back to the initial value on the next tick. Expiries are therefore initial + 1 ticks apart.
- R6: Each 1-to-0 step of the count raises `irq_valid` for exactly one cycle, in the same cycle that `cur_count` first reads 0. `irq_vector` then equals entry bits 7:0.
- R7: While entry bit 16 (mask) is 1, expiries produce no `irq_valid`.
- R8: An initial count of 0 leaves the timer stopped at 0 with no request.
- R9: A current-count write changes neither the count nor its progression.
- R10: Rewriting the timer entry while a count is in progress does not restart or alter the count. The new vector applies to later expiries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_we | input | 1 | Divide-configuration write strobe |
| div_wdata | input | 4 | Divide-configuration write value |
| entry_we | input | 1 | Timer entry write strobe |
| entry_wdata | input | 32 | Timer entry write value (vector 7:0, mask 16, periodic 17) |
| init_we | input | 1 | Initial-count write strobe |
| init_wdata | input | 32 | Initial-count write value |
| cur_we | input | 1 | Current-count write strobe (ignored) |
| cur_wdata | input | 32 | Current-count write value (ignored) |
| div_cfg | output | 4 | Stored divide configuration |
| entry_q | output | 32 | Stored timer entry |
| cur_count | output | 32 | Current count |
| irq_valid | output | 1 | One-cycle expiry request |
| irq_vector | output | 8 | Vector carried by the request |

## Verification
The bench builds the block with its default parameters: a 32-bit count, a 32-bit entry, mask at bit 16 and periodic select at bit 17. It keeps the initial counts small so that each run lasts only a few ticks.

All sixteen divide-configuration values are swept in both modes. This covers every shift from divide-by-1 to divide-by-128, plus the dropped bit 2, within about ten thousand cycles. The bench compares every cycle against an arithmetic model of count and expiry.

Separate runs cover a masked entry, a zero initial count, and mid-count writes to the current count and the entry.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int DIV_CFG_W  = 4;
   localparam int DIV_CODE_W = 3;

   typedef logic [DIV_CODE_W-1:0] div_code_t;
   typedef logic [DIV_CFG_W-1:0]  div_cfg_t;

   // bits kept on a divide-configuration write
   localparam div_cfg_t DIV_KEEP = 4'b1011;

   function automatic div_code_t code_of(input div_cfg_t cfg);
      return {cfg[3], cfg[1], cfg[0]};
   endfunction

   // shift wraps modulo 2^DIV_CODE_W, so the all-ones code gives shift 0
   function automatic div_code_t shift_of(input div_code_t code);
      return code + div_code_t'(1);
   endfunction
endpackage

// File: rtl/tmr_div_cfg.sv
module tmr_div_cfg
   import tmr_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     wr,
   input  div_cfg_t wdata,
   output div_cfg_t cfg_q,
   output div_code_t shift
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cfg_q <= '0;
      else if (wr) cfg_q <= wdata & DIV_KEEP;
   end

   assign shift = shift_of(code_of(cfg_q));

   AST_DIV_BIT2_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (cfg_q[2] == 1'b0)); // R1
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
   parameter int SHIFT_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               restart,
   input  logic [SHIFT_W-1:0] shift,
   output logic               tick
);
   localparam int PRE_W = (1 << SHIFT_W) - 1;

   if (SHIFT_W < 1 || SHIFT_W > 5) begin : g_bad_shift_w
      $error("tmr_prescaler: SHIFT_W out of range");
   end

   logic [PRE_W-1:0] pre_cnt;
   logic [PRE_W:0]   span;
   logic [PRE_W:0]   last;

   assign span = {{PRE_W{1'b0}}, 1'b1} << shift;
   assign last = span - {{PRE_W{1'b0}}, 1'b1};
   // >= keeps the divider safe when the shift is lowered mid-interval
   assign tick = ({1'b0, pre_cnt} >= last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                pre_cnt <= '0;
      else if (restart || tick)  pre_cnt <= '0;
      else                       pre_cnt <= pre_cnt + {{(PRE_W-1){1'b0}}, 1'b1};
   end

   AST_PRESCALE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (restart || tick) |=> (pre_cnt == '0)); // R2
endmodule

// File: rtl/tmr_down_counter.sv
module tmr_down_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             tick,
   input  logic             periodic,
   output logic [CNT_W-1:0] count,
   output logic             expire
);
   if (CNT_W < 2) begin : g_bad_cnt_w
      $error("tmr_down_counter: CNT_W must be at least 2");
   end

   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] reload_q;
   logic             running;
   logic             at_zero;

   assign running = (reload_q != '0);
   assign at_zero = (count == '0);
   assign expire  = !load && tick && running && (count == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count    <= '0;
         reload_q <= '0;
      end else if (load) begin
         count    <= load_val;
         reload_q <= load_val;
      end else if (tick && running) begin
         if (!at_zero)      count <= count - ONE;
         else if (periodic) count <= reload_q;
      end
   end

   AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (count == $past(load_val))); // R3
   AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !tick) |=> $stable(count)); // R2
   AST_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !periodic && at_zero) |=> (count == '0)); // R4
   AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && tick && periodic && running && at_zero) |=> (count == $past(reload_q))); // R5
   AST_STOPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !running && at_zero) |=> (count == '0)); // R8
endmodule

// File: rtl/tmr_expiry_req.sv
module tmr_expiry_req #(
   parameter int VEC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             expire,
   input  logic             masked,
   input  logic [VEC_W-1:0] vec,
   output logic             irq_valid,
   output logic [VEC_W-1:0] irq_vector
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_valid  <= 1'b0;
         irq_vector <= '0;
      end else begin
         irq_valid <= expire && !masked;
         if (expire) irq_vector <= vec;
      end
   end

   AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |=> !irq_valid); // R6
endmodule

// File: rtl/intvl_timer.sv
module intvl_timer
   import tmr_pkg::*;
#(
   parameter int CNT_W        = 32,
   parameter int ENTRY_W      = 32,
   parameter int VEC_W        = 8,
   parameter int MASK_BIT     = 16,
   parameter int PERIODIC_BIT = 17
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               div_we,
   input  logic [3:0]         div_wdata,
   input  logic               entry_we,
   input  logic [ENTRY_W-1:0] entry_wdata,
   input  logic               init_we,
   input  logic [CNT_W-1:0]   init_wdata,
   input  logic               cur_we,
   input  logic [CNT_W-1:0]   cur_wdata,
   output logic [3:0]         div_cfg,
   output logic [ENTRY_W-1:0] entry_q,
   output logic [CNT_W-1:0]   cur_count,
   output logic               irq_valid,
   output logic [VEC_W-1:0]   irq_vector
);
   if (MASK_BIT >= ENTRY_W || PERIODIC_BIT >= ENTRY_W) begin : g_bad_fields
      $error("intvl_timer: entry field outside the entry width");
   end
   if (MASK_BIT == PERIODIC_BIT || VEC_W > MASK_BIT || VEC_W > PERIODIC_BIT) begin : g_bad_overlap
      $error("intvl_timer: entry fields overlap");
   end

   div_code_t shift;
   logic      tick;
   logic      expire;

   // the current-count write port is accepted and discarded
   logic unused_cur_write;
   assign unused_cur_write = ^{cur_we, cur_wdata};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        entry_q <= '0;
      else if (entry_we) entry_q <= entry_wdata;
   end

   tmr_div_cfg u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (div_we),
      .wdata (div_wdata),
      .cfg_q (div_cfg),
      .shift (shift)
   );

   tmr_prescaler #(.SHIFT_W(DIV_CODE_W)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (init_we),
      .shift   (shift),
      .tick    (tick)
   );

   tmr_down_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (init_we),
      .load_val (init_wdata),
      .tick     (tick),
      .periodic (entry_q[PERIODIC_BIT]),
      .count    (cur_count),
      .expire   (expire)
   );

   tmr_expiry_req #(.VEC_W(VEC_W)) u_req (
      .clk        (clk),
      .rst_n      (rst_n),
      .expire     (expire),
      .masked     (entry_q[MASK_BIT]),
      .vec        (entry_q[VEC_W-1:0]),
      .irq_valid  (irq_valid),
      .irq_vector (irq_vector)
   );

   AST_REQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> (cur_count == '0)); // R6
   AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      entry_q[MASK_BIT] |=> !irq_valid); // R7
   AST_CUR_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_we && !init_we && !tick) |=> $stable(cur_count)); // R9
   AST_ENTRY_WRITE_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (entry_we && !init_we && !tick) |=> $stable(cur_count)); // R10
endmodule

// File: tb/intvl_timer_tb_top.sv
module intvl_timer_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        div_we = 1'b0;
   logic [3:0]  div_wdata = '0;
   logic        entry_we = 1'b0;
   logic [31:0] entry_wdata = '0;
   logic        init_we = 1'b0;
   logic [31:0] init_wdata = '0;
   logic        cur_we = 1'b0;
   logic [31:0] cur_wdata = '0;
   logic [3:0]  div_cfg;
   logic [31:0] entry_q;
   logic [31:0] cur_count;
   logic        irq_valid;
   logic [7:0]  irq_vector;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   intvl_timer dut_i (
      .clk(clk), .rst_n(rst_n),
      .div_we(div_we), .div_wdata(div_wdata),
      .entry_we(entry_we), .entry_wdata(entry_wdata),
      .init_we(init_we), .init_wdata(init_wdata),
      .cur_we(cur_we), .cur_wdata(cur_wdata),
      .div_cfg(div_cfg), .entry_q(entry_q), .cur_count(cur_count),
      .irq_valid(irq_valid), .irq_vector(irq_vector)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000 && !done) begin
         errors = errors + 1;
         $display("FAIL watchdog: run did not finish, actual cycle %0d expected below 150000", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks = checks + 1;
      if (!ok) begin
         errors = errors + 1;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // n: initial count, per: periodic, msk: mask, poke: mid-count writes
   task automatic run_case(input logic [3:0] dcfg, input int n, input bit per,
                           input bit msk, input bit poke, input string tag);
      int code;
      int sh;
      int dv;
      int len;
      int t;
      longint exp_cnt;
      bit exp_irq;
      logic [7:0] vec_a;
      logic [7:0] vec_b;
      logic [7:0] exp_vec;
      code  = {dcfg[3], dcfg[1], dcfg[0]};
      sh    = (code + 1) % 8;
      dv    = 1 << sh;
      len   = (2 * (n + 1) + 1) * dv;
      if (len < 12) len = 12;
      vec_a = 8'h30 + 8'(dcfg);
      vec_b = 8'hC5;
      @(negedge clk);
      entry_we    = 1'b1;
      entry_wdata = {14'b0, per, msk, 8'b0, vec_a};
      @(negedge clk);
      entry_we  = 1'b0;
      div_we    = 1'b1;
      div_wdata = dcfg;
      @(negedge clk);
      div_we = 1'b0;
      chk(div_cfg == (dcfg & 4'b1011), "R1 divide readback", div_cfg, dcfg & 4'b1011);
      init_we    = 1'b1;
      init_wdata = n;
      @(negedge clk);
      init_we = 1'b0;
      for (int e = 0; e < len; e++) begin
         t = e / dv;
         if (n == 0)    exp_cnt = 0;
         else if (per)  exp_cnt = n - (t % (n + 1));
         else           exp_cnt = (t >= n) ? 0 : n - t;
         exp_irq = (n != 0) && !msk && (e > 0) && (e % dv == 0) &&
                   (per ? ((t % (n + 1)) == n) : (t == n));
         exp_vec = (poke && e >= 4) ? vec_b : vec_a;
         if (e == 0)
            chk(cur_count == n, "R3 load value", cur_count, n);
         chk(cur_count == exp_cnt, tag, cur_count, exp_cnt);
         chk(irq_valid == exp_irq, msk ? "R7 masked request" : "R6 request timing",
             irq_valid, exp_irq);
         if (exp_irq)
            chk(irq_vector == exp_vec, "R6 vector", irq_vector, exp_vec);
         if (poke && e == 2) begin
            cur_we      = 1'b1;
            cur_wdata   = 32'hFFFF_0000;
            entry_we    = 1'b1;
            entry_wdata = {14'b0, per, msk, 8'b0, vec_b};
         end else begin
            cur_we   = 1'b0;
            entry_we = 1'b0;
         end
         @(negedge clk);
      end
      cur_we   = 1'b0;
      entry_we = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(cur_count == 0, "R3 reset count", cur_count, 0);
      chk(irq_valid == 1'b0, "R6 reset request", irq_valid, 0);
      chk(div_cfg == 4'd0, "R1 reset divide", div_cfg, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cur_count == 0, "R8 idle after reset", cur_count, 0);
      for (int d = 0; d < 16; d++) begin
         run_case(4'(d), 3, 1'b0, 1'b0, 1'b0, "R2 R4 one-shot count");
         run_case(4'(d), 3, 1'b1, 1'b0, 1'b0, "R2 R5 periodic count");
      end
      run_case(4'b1011, 1, 1'b1, 1'b0, 1'b0, "R5 periodic count of 1");
      run_case(4'b0000, 2, 1'b1, 1'b1, 1'b0, "R7 masked count");
      run_case(4'b1011, 0, 1'b1, 1'b0, 1'b0, "R8 zero count");
      run_case(4'b0001, 0, 1'b0, 1'b0, 1'b0, "R8 zero count");
      run_case(4'b1011, 6, 1'b0, 1'b0, 1'b1, "R9 R10 mid-count writes");
      run_case(4'b0000, 5, 1'b1, 1'b0, 1'b1, "R9 R10 mid-count writes");
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule